// File: doc/BRIEF.md
# Interrupt CPU Interface: Acknowledge and End-of-Interrupt

This block sits between an interrupt distributor and one processor core. Each cycle it receives the distributor's pending interrupt lines, a priority value per interrupt, and, for the sixteen software-generated IDs, the number of the core that raised each one. It keeps its own record of which interrupts are active. From the interrupts that are pending, not active, and under the priority threshold, it picks the most urgent one. It raises a single request line to the core while that interface is enabled and such an interrupt exists.

Software has a small register port with four word addresses. Address 0 is control. Address 1 is the priority threshold. Address 2 is acknowledge, and reading it has side effects. Address 3 is end-of-interrupt, which is write-only. Reading acknowledge returns the winning ID and marks that interrupt active in the same cycle. A one-cycle strobe then tells the distributor which ID was taken. When nothing qualifies, the read returns a spurious ID. Writing back the value that was read retires the interrupt, and a matching strobe goes to the distributor. A handler can read acknowledge repeatedly until it receives an ID above 1020.

Top module: `cpuif_ack_eoi`

## Requirements
- R1: A read of address 2 while an eligible interrupt exists returns that interrupt's ID in bits [9:0] and marks it active. An active interrupt is not returned again until it is retired.
- R2: Among eligible interrupts, the one with the numerically lowest priority value wins. When priority values are equal, the lowest ID wins.
- R3: A read of address 2 returns 1023 in bits [9:0] when the interface is disabled or nothing is eligible. Such a read changes no active state and gives no acknowledge strobe.
- R4: An interrupt is eligible only when it is pending, not active, and its priority value is strictly below the threshold held in address 1, bits [PRIO_W-1:0].
- R5: For IDs 0 to 15, the acknowledge word carries the source core number in bits [12:10]. For other IDs those bits read zero.
- R6: A write to address 3 takes the ID from bits [9:0] and clears that interrupt's active flag. It pulses `eoi_valid_o` with `eoi_id_o` one cycle later. An ID at or above NUM_IRQ gives no strobe.
- R7: In the control register at address 0, bit 0 is the enable and bits [2:1] are bypass-disable bits. Both fields are stored independently and read back as written. All other bits read zero. The threshold reads back as written.
- R8: `irq_o` is the registered value of (enable AND at least one eligible interrupt). It is low whenever the enable was low in the previous cycle.
- R9: A successful acknowledge read pulses `ack_valid_o` for one cycle, with `ack_id_o` equal to the returned ID. The pulse comes in the same cycle as `reg_rvalid_o`.
- R10: After reset, control and threshold are zero, no interrupt is active, and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_rd_i | input | 1 | Register read request |
| reg_wr_i | input | 1 | Register write request |
| reg_addr_i | input | 2 | Word address: 0 control, 1 threshold, 2 acknowledge, 3 end-of-interrupt |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid with reg_rvalid_o |
| reg_rvalid_o | output | 1 | Read data valid, one cycle after the request |
| pend_i | input | NUM_IRQ | Pending lines from the distributor |
| prio_i | input | NUM_IRQ*PRIO_W | Priority per interrupt; ID n uses bits [n*PRIO_W +: PRIO_W] |
| sgi_src_i | input | 16*CPU_W | Source core for each software-generated ID |
| irq_o | output | 1 | Interrupt request to the core |
| ack_valid_o | output | 1 | Acknowledge strobe to the distributor |
| ack_id_o | output | 10 | ID that was acknowledged |
| eoi_valid_o | output | 1 | End-of-interrupt strobe to the distributor |
| eoi_id_o | output | 10 | ID that was retired |

## Verification
The hardest state to reach is a pending interrupt that is still held high by the distributor but is already active. In that state the pending line alone does not cause a signal. The stimulus leaves the pending lines asserted across several acknowledge reads, so the remaining candidates are taken one at a time, including equal-priority ones. After the last one, a spurious ID must appear and the request line must drop. The bench then retires one interrupt while its line is still pending, and checks that this interrupt alone becomes available again.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;
  localparam int ID_W = 10;
  localparam int SGI_COUNT = 16;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_PMASK = 2'd1,
    REG_ACK   = 2'd2,
    REG_EOI   = 2'd3
  } cpuif_reg_e;
endpackage

// File: rtl/cpuif_arbiter.sv
module cpuif_arbiter #(
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W  = 8,
  localparam int IDX_W  = $clog2(NUM_IRQ)
) (
  input  logic [NUM_IRQ-1:0]        elig_i,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
  output logic                      valid_o,
  output logic [IDX_W-1:0]          idx_o
);
  logic [PRIO_W-1:0] best_prio;

  // Ascending scan with a strict compare: on equal priority the lower ID stays.
  always_comb begin
    valid_o   = 1'b0;
    idx_o     = '0;
    best_prio = '1;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (elig_i[i] && (!valid_o || (prio_i[i*PRIO_W +: PRIO_W] < best_prio))) begin
        valid_o   = 1'b1;
        idx_o     = IDX_W'(i);
        best_prio = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/cpuif_active.sv
module cpuif_active #(
  parameter int NUM_IRQ = 64,
  localparam int IDX_W  = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_en_i,
  input  logic [IDX_W-1:0]   set_idx_i,
  input  logic               clr_en_i,
  input  logic [IDX_W-1:0]   clr_idx_i,
  output logic [NUM_IRQ-1:0] active_o
);
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        active_o[g] <= 1'b0;
      else if (set_en_i && (set_idx_i == IDX_W'(g)))
        active_o[g] <= 1'b1;
      else if (clr_en_i && (clr_idx_i == IDX_W'(g)))
        active_o[g] <= 1'b0;
    end
  end

  // R1
  mark_active_chk: assert property (@(posedge clk) disable iff (rst)
    set_en_i |=> active_o[$past(set_idx_i)]);

  // R6
  retire_active_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_en_i && !(set_en_i && (set_idx_i == clr_idx_i))) |=> !active_o[$past(clr_idx_i)]);
endmodule

// File: rtl/cpuif_ack_eoi.sv
module cpuif_ack_eoi
  import cpuif_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W  = 8,
  parameter int CPU_W   = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      reg_rd_i,
  input  logic                      reg_wr_i,
  input  logic [1:0]                reg_addr_i,
  input  logic [31:0]               reg_wdata_i,
  output logic [31:0]               reg_rdata_o,
  output logic                      reg_rvalid_o,
  input  logic [NUM_IRQ-1:0]        pend_i,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
  input  logic [SGI_COUNT*CPU_W-1:0] sgi_src_i,
  output logic                      irq_o,
  output logic                      ack_valid_o,
  output logic [ID_W-1:0]           ack_id_o,
  output logic                      eoi_valid_o,
  output logic [ID_W-1:0]           eoi_id_o
);
  localparam int IDX_W = $clog2(NUM_IRQ);
  localparam logic [ID_W-1:0] ID_LIMIT = ID_W'(NUM_IRQ);

  logic              ctrl_en_q;
  logic [1:0]        bypass_q;
  logic [PRIO_W-1:0] pmask_q;
  logic [NUM_IRQ-1:0] active, below_mask, elig;
  logic              best_valid;
  logic [IDX_W-1:0]  best_idx;
  cpuif_reg_e        addr;
  logic              do_ack, do_eoi;
  logic [ID_W-1:0]   eoi_id_w;
  logic [3:0]        sgi_sel;
  logic [31:0]       ack_word, rd_mux;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_thresh
    assign below_mask[g] = prio_i[g*PRIO_W +: PRIO_W] < pmask_q;
  end

  assign elig = pend_i & ~active & below_mask;

  cpuif_arbiter #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_arb (
    .elig_i  (elig),
    .prio_i  (prio_i),
    .valid_o (best_valid),
    .idx_o   (best_idx)
  );

  assign addr     = cpuif_reg_e'(reg_addr_i);
  assign do_ack   = reg_rd_i && (addr == REG_ACK) && ctrl_en_q && best_valid;
  assign eoi_id_w = reg_wdata_i[ID_W-1:0];
  assign do_eoi   = reg_wr_i && (addr == REG_EOI) && (eoi_id_w < ID_LIMIT);
  assign sgi_sel  = best_idx[3:0];

  cpuif_active #(.NUM_IRQ(NUM_IRQ)) u_active (
    .clk       (clk),
    .rst       (rst),
    .set_en_i  (do_ack),
    .set_idx_i (best_idx),
    .clr_en_i  (do_eoi),
    .clr_idx_i (eoi_id_w[IDX_W-1:0]),
    .active_o  (active)
  );

  always_comb begin
    ack_word = '0;
    if (ctrl_en_q && best_valid) begin
      ack_word[ID_W-1:0] = ID_W'(best_idx);
      if (best_idx < IDX_W'(SGI_COUNT))
        ack_word[ID_W +: CPU_W] = sgi_src_i[sgi_sel*CPU_W +: CPU_W];
    end else begin
      ack_word[ID_W-1:0] = SPURIOUS_ID;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      REG_CTRL:  rd_mux[2:0] = {bypass_q, ctrl_en_q};
      REG_PMASK: rd_mux[PRIO_W-1:0] = pmask_q;
      REG_ACK:   rd_mux = ack_word;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en_q    <= 1'b0;
      bypass_q     <= '0;
      pmask_q      <= '0;
      reg_rdata_o  <= '0;
      reg_rvalid_o <= 1'b0;
      ack_valid_o  <= 1'b0;
      ack_id_o     <= '0;
      eoi_valid_o  <= 1'b0;
      eoi_id_o     <= '0;
      irq_o        <= 1'b0;
    end else begin
      reg_rvalid_o <= reg_rd_i;
      if (reg_rd_i) reg_rdata_o <= rd_mux;
      ack_valid_o <= do_ack;
      if (do_ack) ack_id_o <= ID_W'(best_idx);
      eoi_valid_o <= do_eoi;
      if (do_eoi) eoi_id_o <= eoi_id_w;
      if (reg_wr_i && (addr == REG_CTRL)) begin
        ctrl_en_q <= reg_wdata_i[0];
        bypass_q  <= reg_wdata_i[2:1];
      end
      if (reg_wr_i && (addr == REG_PMASK)) pmask_q <= reg_wdata_i[PRIO_W-1:0];
      irq_o <= ctrl_en_q && (|elig);
    end
  end

  // R8
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(ctrl_en_q));

  // R9
  ack_pairs_read_chk: assert property (@(posedge clk) disable iff (rst)
    ack_valid_o |-> (reg_rvalid_o && (reg_rdata_o[ID_W-1:0] == ack_id_o)));

  // R3
  spurious_no_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rvalid_o && (reg_rdata_o[ID_W-1:0] == SPURIOUS_ID)) |-> !ack_valid_o);

  // R6
  eoi_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    eoi_valid_o |-> (eoi_id_o < ID_LIMIT));
endmodule

// File: tb/cpuif_ack_eoi_test.sv
module cpuif_ack_eoi_test;
  localparam int N = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic rvalid, irq, ackv, eoiv;
  logic [9:0] ack_id, eoi_id;
  logic [N-1:0] pend = '0;
  logic [N-1:0][7:0] prio = '0;
  logic [15:0][2:0] src = '0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] data;
    logic        ackv;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  cpuif_ack_eoi #(.NUM_IRQ(N), .PRIO_W(8), .CPU_W(3)) uut (
    .clk(clk), .rst(rst), .reg_rd_i(rd), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .reg_rvalid_o(rvalid),
    .pend_i(pend), .prio_i(prio), .sgi_src_i(src), .irq_o(irq),
    .ack_valid_o(ackv), .ack_id_o(ack_id), .eoi_valid_o(eoiv), .eoi_id_o(eoi_id)
  );

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected item per returned read.
  always @(negedge clk) begin
    if (rvalid && q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      check(rdata == e.data, e.tag, rdata, e.data);
      check(ackv == e.ackv, {e.tag, " R9 strobe"}, 32'(ackv), 32'(e.ackv));
      if (e.ackv) check(ack_id == e.data[9:0], {e.tag, " R9 id"}, 32'(ack_id), 32'(e.data[9:0]));
    end
  end

  task automatic do_rd(input logic [1:0] a);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic rd_expect(input logic [1:0] a, input logic [31:0] d, input logic av, input string tag);
    exp_t e;
    e.data = d; e.ackv = av; e.tag = tag;
    q.push_back(e);
    do_rd(a);
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(irq == 1'b0, "R10 irq after reset", 32'(irq), 0);
    rd_expect(2'd0, 32'h0, 1'b0, "R10 ctrl reset");
    rd_expect(2'd1, 32'h0, 1'b0, "R10 mask reset");
    rd_expect(2'd2, 32'd1023, 1'b0, "R3 ack while disabled");

    // R7 control and threshold read back
    do_wr(2'd0, 32'h107);
    rd_expect(2'd0, 32'h7, 1'b0, "R7 ctrl readback");
    do_wr(2'd1, 32'hF0);
    rd_expect(2'd1, 32'hF0, 1'b0, "R7 mask readback");

    // R2 priority then lowest ID on ties
    prio[40] = 8'h20; prio[35] = 8'h20; prio[50] = 8'h10;
    pend[40] = 1'b1; pend[35] = 1'b1; pend[50] = 1'b1;
    settle();
    check(irq == 1'b1, "R8 irq with eligible", 32'(irq), 1);
    rd_expect(2'd2, 32'd50, 1'b1, "R2 lowest value wins");
    rd_expect(2'd2, 32'd35, 1'b1, "R2 tie lowest id");
    rd_expect(2'd2, 32'd40, 1'b1, "R1 next candidate");
    rd_expect(2'd2, 32'd1023, 1'b0, "R1 R3 all active spurious");
    settle();
    check(irq == 1'b0, "R8 irq drops when all active", 32'(irq), 0);

    // R6 retire while still pending
    do_wr(2'd3, 32'd35);
    check(eoiv == 1'b1, "R6 eoi strobe", 32'(eoiv), 1);
    check(eoi_id == 10'd35, "R6 eoi id", 32'(eoi_id), 35);
    rd_expect(2'd2, 32'd35, 1'b1, "R6 retired id returns");
    pend = '0;
    do_wr(2'd3, 32'd35); do_wr(2'd3, 32'd50); do_wr(2'd3, 32'd40);

    // R4 threshold is strict
    prio[20] = 8'hF0; pend[20] = 1'b1;
    settle();
    check(irq == 1'b0, "R4 irq at threshold", 32'(irq), 0);
    rd_expect(2'd2, 32'd1023, 1'b0, "R4 equal to mask not eligible");
    do_wr(2'd1, 32'hF1);
    rd_expect(2'd2, 32'd20, 1'b1, "R4 below mask eligible R5 no source");
    pend[20] = 1'b0;
    do_wr(2'd3, 32'd20);

    // R5 software ID carries source core
    src[3] = 3'd5; prio[3] = 8'h00; pend[3] = 1'b1;
    rd_expect(2'd2, 32'h1403, 1'b1, "R5 source field");
    pend[3] = 1'b0;
    do_wr(2'd3, 32'h1403);
    check(eoiv == 1'b1 && eoi_id == 10'd3, "R6 eoi with read value", 32'(eoi_id), 3);

    // R6 out of range ID ignored
    do_wr(2'd3, 32'd1000);
    check(eoiv == 1'b0, "R6 out of range no strobe", 32'(eoiv), 0);

    // R3 R8 disable keeps bypass bits
    prio[45] = 8'h05; pend[45] = 1'b1;
    do_wr(2'd0, 32'h6);
    rd_expect(2'd0, 32'h6, 1'b0, "R7 bypass kept with enable off");
    settle();
    check(irq == 1'b0, "R8 irq when disabled", 32'(irq), 0);
    rd_expect(2'd2, 32'd1023, 1'b0, "R3 disabled spurious");
    do_wr(2'd0, 32'h7);
    settle();
    check(irq == 1'b1, "R8 irq re-enabled", 32'(irq), 1);
    rd_expect(2'd2, 32'd45, 1'b1, "R3 no side effect on disabled read");
    pend[45] = 1'b0;
    do_wr(2'd3, 32'd45);

    // R1 R2 handler loop until ID above 1020
    prio[16] = 8'h30; prio[33] = 8'h10; prio[60] = 8'h20;
    pend[16] = 1'b1; pend[33] = 1'b1; pend[60] = 1'b1;
    begin
      logic [9:0] order[3];
      int n;
      order[0] = 10'd33; order[1] = 10'd60; order[2] = 10'd16;
      n = 0;
      for (int k = 0; k < 8; k++) begin
        do_rd(2'd2);
        if (rdata[9:0] > 10'd1020) break;
        if (n < 3) check(rdata[9:0] == order[n], "R1 R2 loop order", 32'(rdata[9:0]), 32'(order[n]));
        n++;
      end
      check(n == 3, "R1 loop count", 32'(n), 3);
    end
    pend = '0;
    do_wr(2'd3, 32'd33); do_wr(2'd3, 32'd60); do_wr(2'd3, 32'd16);
    settle();
    check(q.size() == 0, "R9 all reads returned", 32'(q.size()), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule